// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that answers on a shared two-wire bus like a small serial EEPROM. It stores 256 bytes. It takes the bus clock and data lines through synchronizing, glitch-rejecting input stages. It pulls the data line low through a single output-enable, and the pad's pull-up supplies the high level. The target detects START, repeated START and STOP conditions.

It offers these transfers:
- single-byte and page writes, with one word-address byte;
- current-address reads;
- random reads, where an address-only write is followed by a repeated START;
- sequential reads.

Written bytes are held in a page buffer. They reach the array only when the host sends STOP. A busy period of programmable length then follows, and during it the target ignores its own address. This lets a host find the end of the write cycle by polling for an acknowledge. A write-protect input stops any commit. Three strap inputs choose one of eight bus addresses.

The block connects straight to a pad pair. The strap and write-protect pins are tied by the board. `WRITE_CYCLES` sets the length of the write cycle in clock periods.

Top module: `eeprom_i2c_target`

## Requirements
- R1: The target answers only to a control byte whose upper seven bits are 1010 followed by `sel_i[2:0]`. Bit 0 of the control byte selects read (1) or write (0). A control byte with any other address gets no acknowledge, and the bytes that follow it up to the next START have no effect.
- R2: A write made of control byte, word address, one data byte and STOP stores the data byte at the word address. The target acknowledges each of these bytes by pulling SDA low through the ninth clock.
- R3: In a page write, the data bytes go to consecutive addresses. The low 4 address bits roll over inside the 16-byte page and the upper 4 bits stay fixed, so a 17th byte replaces the first.
- R4: Buffered write bytes reach the array only at STOP. A repeated START drops them, and no write cycle follows.
- R5: A commit starts a write cycle of `WRITE_CYCLES` clocks. During the cycle the target does not acknowledge its control byte. After the cycle ends, it acknowledges again.
- R6: While `wp_i` is high at STOP, the array is left unchanged and no write cycle starts. Every write byte is still acknowledged.
- R7: A random read returns the byte at the given word address, most significant bit first. A random read is an address-only write, then a repeated START, then a read control byte.
- R8: In a sequential read the address advances after every byte and wraps from 255 to 0. A host NACK ends the read, and SDA is released.
- R9: A current-address read returns the byte one past the last address read or written.
- R10: A pulse shorter than `FILT_LEN` clocks on SCL or SDA has no effect. It creates no clock edge, START or STOP.
- R11: Reset releases SDA and clears the address to 0 and the busy state. Every array byte is set to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wp_i | input | 1 | Write protect; 1 blocks commits |
| sel_i | input | 3 | Address strap bits, low three bits of the bus address |

## Verification
Every response comes from the filtered lines, so it lags a bus edge by the synchronizer and filter depth plus one register. That is about seven clocks with the default parameters. Acknowledge and read-data levels therefore appear on SDA that many clocks after the SCL falling edge.

The bench holds each quarter of a bus bit for ten clocks. It samples SDA halfway through the SCL high phase, well after that lag and well before the next change. The write cycle is counted from the clock on which STOP is filtered. The bench sets it longer than one control byte, so the first poll after a commit falls inside the cycle and a later poll falls outside it.

// File: rtl/ee_pkg.sv
// Shared constants and state encoding for the I2C EEPROM target.
// Assumes an 8-bit word address split into a page number and a
// 4-bit offset inside the page.
package ee_pkg;
    localparam int          ADDR_W   = 8;
    localparam int          PAGE_W   = 4;
    localparam logic [3:0]  DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,   // not addressed, waiting for START
        S_CTRL,   // shifting in the control byte
        S_CACK,   // acknowledging the control byte
        S_WADR,   // shifting in the word address
        S_AACK,   // acknowledging the word address
        S_WDAT,   // shifting in a write data byte
        S_DACK,   // acknowledging a write data byte
        S_RDAT,   // shifting out a read byte
        S_RACK    // sampling the host acknowledge
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
// Synchronizes one open-drain bus line into the clock domain and
// rejects pulses shorter than FILT clocks. The output changes only
// after FILT consecutive synchronized samples agree.
// Assumes the line idles high.
module i2c_line_filter #(
    parameter int SYNC = 2,
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int W = SYNC + FILT;

    logic [W-1:0]    sr;
    logic [FILT-1:0] win;
    logic            out_q;

    assign win    = sr[W-1:SYNC];
    assign line_o = out_q;

    // shift the raw line through the synchronizer and the window
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[W-2:0], line_i};
    end

    // take a new level only when the whole window agrees
    always_ff @(posedge clk) begin
        if (!rst_n)             out_q <= 1'b1;
        else if (win == '1)     out_q <= 1'b1;
        else if (win == '0)     out_q <= 1'b0;
    end

    p_glitch_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> ($past(win) == {FILT{out_q}}));
endmodule

// File: rtl/ee_busy_timer.sv
// Models the internal write cycle. A start pulse loads CYCLES, and busy
// stays high until the count drains to zero.
// Assumes start only arrives at a STOP.
module ee_busy_timer #(
    parameter int CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // load on start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (start_i)      cnt <= CW'(CYCLES);
        else if (cnt != '0)    cnt <= cnt - CW'(1);
    end

    assign busy_o = (cnt != '0);

    p_busy_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/ee_array.sv
// Register-file storage with a one-page write buffer. Bytes land in the
// buffer with a valid bit per offset. A commit copies the valid bytes
// into the array page last written, and a clear drops them.
// Assumes commit and buffer writes never coincide.
module ee_array #(
    parameter int AW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [AW-PW-1:0] wr_page_i,
    input  logic [7:0]    wr_data_i,
    input  logic          clr_i,
    input  logic          commit_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    output logic          pend_o
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PW;
    localparam int PGW   = AW - PW;

    logic [DEPTH-1:0][7:0] mem;
    logic [PAGE-1:0][7:0]  pbuf;
    logic [PAGE-1:0]       vld;
    logic [PGW-1:0]        pg;

    // collect write bytes and their offsets until commit or clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            pg  <= '0;
        end else if (commit_i || clr_i) begin
            vld <= '0;
        end else if (wr_i) begin
            pbuf[wr_idx_i] <= wr_data_i;
            vld[wr_idx_i]  <= 1'b1;
            pg             <= wr_page_i;
        end
    end

    // copy valid buffer bytes into the selected page on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= {DEPTH{8'hFF}};
        end else if (commit_i) begin
            for (int i = 0; i < PAGE; i++) begin
                if (vld[i]) mem[{pg, PW'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];
    assign pend_o    = |vld;

    p_array_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(mem));
endmodule

// File: rtl/eeprom_i2c_target.sv
// I2C target acting as a 256 x 8 serial EEPROM. It filters SCL and SDA,
// finds START and STOP, and runs the byte-level protocol. Writes are
// buffered and committed at STOP, followed by a busy period in which
// the target ignores its own address.
// Assumes the pad drives SDA low whenever sda_oe_o is high. The host
// keeps each SCL phase longer than the filter latency.
module eeprom_i2c_target
    import ee_pkg::*;
#(
    parameter int WRITE_CYCLES = 1000000,
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_LEN     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       wp_i,
    input  logic [2:0] sel_i
);
    logic scl_f, sda_f, scl_d, sda_d;
    logic scl_rise, scl_fall, start_evt, stop_evt;
    logic busy, pend, commit, byte_wr, addr_hit;
    logic [7:0] rd_data;

    tgt_state_e        st;
    logic [3:0]        bitcnt;
    logic [7:0]        rxsh, txsh;
    logic [ADDR_W-1:0] ptr;
    logic              rw_q, hack_q, oe_q;

    i2c_line_filter #(.SYNC(SYNC_STAGES), .FILT(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    i2c_line_filter #(.SYNC(SYNC_STAGES), .FILT(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    // keep the previous filtered levels for edge and condition detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_d;
    assign scl_fall  = ~scl_f & scl_d;
    assign start_evt = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_evt  = scl_f & scl_d & ~sda_d & sda_f;
    assign addr_hit  = (rxsh[7:1] == {DEV_CODE, sel_i}) && !busy;
    assign byte_wr   = (st == S_WDAT) && scl_fall && (bitcnt == 4'd8);
    assign commit    = stop_evt && pend && !wp_i;
    assign sda_oe_o  = oe_q;

    ee_busy_timer #(.CYCLES(WRITE_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy));

    ee_array #(.AW(ADDR_W), .PW(PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_i(byte_wr), .wr_idx_i(ptr[PAGE_W-1:0]),
        .wr_page_i(ptr[ADDR_W-1:PAGE_W]), .wr_data_i(rxsh),
        .clr_i(start_evt), .commit_i(commit),
        .rd_addr_i(ptr), .rd_data_o(rd_data), .pend_o(pend));

    // byte-level protocol: shift, acknowledge, transmit, follow host ack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            bitcnt <= '0;
            rxsh   <= '0;
            txsh   <= '0;
            ptr    <= '0;
            rw_q   <= 1'b0;
            hack_q <= 1'b0;
            oe_q   <= 1'b0;
        end else if (start_evt) begin
            st     <= S_CTRL;
            bitcnt <= '0;
            oe_q   <= 1'b0;
        end else if (stop_evt) begin
            st     <= S_IDLE;
            oe_q   <= 1'b0;
        end else begin
            case (st)
                S_CTRL, S_WADR, S_WDAT: begin
                    if (scl_rise) begin
                        rxsh   <= {rxsh[6:0], sda_f};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        if (st == S_CTRL) begin
                            if (addr_hit) begin
                                oe_q <= 1'b1;
                                rw_q <= rxsh[0];
                                st   <= S_CACK;
                            end else begin
                                st   <= S_IDLE;
                            end
                        end else if (st == S_WADR) begin
                            ptr  <= rxsh;
                            oe_q <= 1'b1;
                            st   <= S_AACK;
                        end else begin
                            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                            oe_q <= 1'b1;
                            st   <= S_DACK;
                        end
                    end
                end
                S_CACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            txsh   <= rd_data;
                            oe_q   <= ~rd_data[7];
                            bitcnt <= '0;
                            st     <= S_RDAT;
                        end else begin
                            oe_q   <= 1'b0;
                            st     <= S_WADR;
                        end
                    end
                end
                S_AACK, S_DACK: begin
                    if (scl_fall) begin
                        oe_q <= 1'b0;
                        st   <= S_WDAT;
                    end
                end
                S_RDAT: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            oe_q <= 1'b0;
                            ptr  <= ptr + 1'b1;
                            st   <= S_RACK;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                            txsh   <= {txsh[6:0], 1'b0};
                            oe_q   <= ~txsh[6];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        hack_q <= ~sda_f;
                    end else if (scl_fall) begin
                        if (hack_q) begin
                            txsh   <= rd_data;
                            oe_q   <= ~rd_data[7];
                            bitcnt <= '0;
                            st     <= S_RDAT;
                        end else begin
                            st     <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    p_sda_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scl_d |-> $stable(oe_q));
    p_busy_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CACK) |-> !busy);
    p_wp_no_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && wp_i && !busy) |=> !busy);
    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wr |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
endmodule

// File: tb/eeprom_i2c_target_tb.sv
`timescale 1ns/1ps
module eeprom_i2c_target_tb;
    localparam int         Q   = 10;
    localparam int         WC  = 600;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] CW  = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] CR  = {4'b1010, SEL, 1'b1};
    // byte-write vectors: {word address, data}
    localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h0F5A, 16'h1000,
                                        16'h7EC3, 16'hFF81, 16'h4218};

    logic clk = 1'b0, rst_n = 1'b0, scl_h = 1'b1, sda_h = 1'b1, wp = 1'b0;
    logic sda_oe, sda_line, last_oe;
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];
    int n_chk = 0, n_err = 0;
    bit done = 0;

    assign sda_line = sda_h & ~sda_oe;

    eeprom_i2c_target #(.WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .wp_i(wp), .sel_i(SEL));

    always #2.5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q); scl_h = 1'b1; tick(Q); sda_h = 1'b1; tick(Q);
    endtask

    // glitch: 0 none, 1 short SCL pulse in a low phase, 2 short SDA flip in a high phase
    task automatic send_byte(input logic [7:0] b, input int glitch, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; tick(Q); scl_h = 1'b1; tick(Q);
            if (glitch == 2 && i == 4) begin
                sda_h = ~b[i]; tick(2); sda_h = b[i]; tick(Q - 2);
            end else tick(Q);
            scl_h = 1'b0;
            if (glitch == 1 && i == 4) begin
                tick(4); scl_h = 1'b1; tick(2); scl_h = 1'b0; tick(Q - 6);
            end else tick(Q);
        end
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_h = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_h = 1'b0; tick(Q);
        end
        sda_h = ~give_ack; tick(Q); scl_h = 1'b1; tick(2 * Q); scl_h = 1'b0; tick(Q);
        last_oe = sda_oe;
        sda_h = 1'b1;
    endtask

    task automatic ee_write(input logic [7:0] a, input int n, input int glitch, output logic all_ack);
        logic k;
        all_ack = 1'b1;
        bus_start();
        send_byte(CW, 0, k); all_ack &= k;
        send_byte(a, 0, k);  all_ack &= k;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], (i == 0) ? glitch : 0, k); all_ack &= k;
        end
        bus_stop();
    endtask

    task automatic poll_ready(output int tries);
        logic k;
        tries = 0;
        do begin
            tries++;
            bus_start(); send_byte(CW, 0, k); bus_stop();
        end while (!k && tries < 20);
    endtask

    task automatic rand_read(input logic [7:0] a, input int n);
        logic k;
        bus_start(); send_byte(CW, 0, k); send_byte(a, 0, k);
        bus_start(); send_byte(CR, 0, k);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic cur_read();
        logic k;
        bus_start(); send_byte(CR, 0, k); recv_byte(1'b0, rbuf[0]); bus_stop();
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic ok, k;
        int tries;
        // R11: reset state
        tick(10);
        check("R11 sda released in reset", {31'd0, sda_oe}, 32'd0);
        rst_n = 1'b1; tick(10);
        check("R11 sda released after reset", {31'd0, sda_oe}, 32'd0);
        cur_read();
        check("R11 erased byte at address 0", {24'd0, rbuf[0]}, 32'hFF);

        // R2 R5 R7: table of byte writes, each polled and read back
        for (int v = 0; v < 6; v++) begin
            wbuf[0] = VEC[v][7:0];
            ee_write(VEC[v][15:8], 1, 0, ok);
            check("R2 byte write acknowledged", {31'd0, ok}, 32'd1);
            poll_ready(tries);
            check("R5 poll nacked during write cycle", {31'd0, tries >= 2}, 32'd1);
            rand_read(VEC[v][15:8], 1);
            check("R7 random read data", {24'd0, rbuf[0]}, {24'd0, VEC[v][7:0]});
        end

        // R1: foreign address gets no ack and its write has no effect
        bus_start();
        send_byte({4'b1010, SEL ^ 3'b001, 1'b0}, 0, k);
        check("R1 foreign address not acked", {31'd0, k}, 32'd0);
        send_byte(8'h00, 0, k); send_byte(8'h11, 0, k); bus_stop();
        poll_ready(tries);
        check("R1 no write cycle after foreign write", tries, 32'd1);
        rand_read(8'h00, 1);
        check("R1 array untouched", {24'd0, rbuf[0]}, 32'hA5);

        // R3: 16-byte page write starting mid page wraps inside the page
        for (int i = 0; i < 16; i++) wbuf[i] = 8'h60 + 8'(i);
        ee_write(8'h23, 16, 0, ok);
        check("R3 page write acked", {31'd0, ok}, 32'd1);
        poll_ready(tries);
        for (int i = 0; i < 17; i++) wbuf[i] = 8'h90 + 8'(i);
        ee_write(8'h50, 17, 0, ok);
        check("R3 17-byte write acked", {31'd0, ok}, 32'd1);
        poll_ready(tries);
        rand_read(8'h1F, 18);
        check("R3 byte below page", {24'd0, rbuf[0]}, 32'hFF);
        for (int j = 0; j < 16; j++)
            check("R3 wrapped page byte", {24'd0, rbuf[j + 1]}, 32'h60 + ((j + 13) % 16));
        check("R3 byte above page", {24'd0, rbuf[17]}, 32'hFF);
        rand_read(8'h50, 2);
        check("R3 17th byte replaces first", {24'd0, rbuf[0]}, 32'hA0);
        check("R3 second page byte", {24'd0, rbuf[1]}, 32'h91);

        // R8: sequential read wraps from 255 to 0 and releases on NACK
        rand_read(8'hFE, 4);
        check("R8 seq byte FE", {24'd0, rbuf[0]}, 32'hFF);
        check("R8 seq byte FF", {24'd0, rbuf[1]}, 32'h81);
        check("R8 seq wrap to 00", {24'd0, rbuf[2]}, 32'hA5);
        check("R8 seq byte 01", {24'd0, rbuf[3]}, 32'hFF);
        check("R8 sda released after nack", {31'd0, last_oe}, 32'd0);

        // R9: current-address read follows the last access
        rand_read(8'h0F, 1);
        check("R9 setup read", {24'd0, rbuf[0]}, 32'h5A);
        cur_read();
        check("R9 current address read", {24'd0, rbuf[0]}, 32'h00);

        // R4: repeated START drops buffered bytes
        bus_start(); send_byte(CW, 0, k); send_byte(8'h42, 0, k); send_byte(8'hEE, 0, k);
        bus_start(); send_byte(CW, 0, k); bus_stop();
        poll_ready(tries);
        check("R4 no write cycle after restart", tries, 32'd1);
        rand_read(8'h42, 1);
        check("R4 dropped byte not stored", {24'd0, rbuf[0]}, 32'h18);

        // R6: write protect keeps the array and skips the write cycle
        wp = 1'b1;
        wbuf[0] = 8'h77;
        ee_write(8'h0F, 1, 0, ok);
        check("R6 protected write still acked", {31'd0, ok}, 32'd1);
        poll_ready(tries);
        check("R6 no write cycle when protected", tries, 32'd1);
        wp = 1'b0;
        rand_read(8'h0F, 1);
        check("R6 protected byte unchanged", {24'd0, rbuf[0]}, 32'h5A);

        // R10: short pulses on SCL and SDA are ignored
        wbuf[0] = 8'h3C;
        ee_write(8'h80, 1, 1, ok);
        poll_ready(tries);
        rand_read(8'h80, 1);
        check("R10 SCL glitch ignored", {24'd0, rbuf[0]}, 32'h3C);
        wbuf[0] = 8'hC3;
        ee_write(8'h81, 1, 2, ok);
        poll_ready(tries);
        check("R10 SDA glitch gave no false STOP", {31'd0, tries >= 2}, 32'd1);
        rand_read(8'h81, 1);
        check("R10 SDA glitch ignored", {24'd0, rbuf[0]}, 32'hC3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule